// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry

This block forms the second ALU operand of a data-processing instruction from a 32-bit register value. It takes the 12-bit operand field of the instruction, the low byte of a second register and the current carry flag. From the field it decodes the shift kind and where the shift amount comes from. It then applies a logical left, logical right, arithmetic right or rotate right shift, and it produces the shifted value together with the shifter carry-out.

Zero amounts and large amounts carry defined meanings. These special cases are resolved in a decode stage ahead of a shift core that has no special cases of its own. In an immediate-amount instruction, a zero amount stands for a pass-through, a shift by 32, or a one-bit rotate through carry, depending on the shift kind. A register amount of zero passes the value through unchanged. Register amounts of 32 and above saturate.

The result and the carry are registered, so both appear one clock after the inputs are presented. Reset is synchronous and active high.

Top module: `opnd_shifter`

## Requirements
- R1: Bits [6:5] of the operand field select the shift kind: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. The result and carry-out appear on the outputs one clock edge after the inputs.
- R2: Bit 4 of the operand field selects the amount source. When it is 0, the amount is the 5-bit unsigned value in bits [11:7]. When it is 1, the amount is the full 8-bit `rs_byte` input, bit 7 of the field is 0, and bits [11:8] name the register that supplied the byte.
- R3: A logical left shift by n, with 1 <= n <= 32, fills the low n bits with zeros and drops the bits shifted out at the top. The carry-out is input bit (32 - n).
- R4: An immediate-form logical left shift with an amount of 0 outputs the input unchanged, and the carry-out equals `carry_in`.
- R5: A logical or arithmetic right shift by n, with 1 <= n <= 32, gives carry-out = input bit (n - 1). The logical form fills with zeros and the arithmetic form fills with input bit 31. An immediate amount of 0 means n = 32 for both forms.
- R6: An immediate-form rotate with an amount of 0 rotates right by one through the carry. Result bit 31 is `carry_in`, result bits [30:0] are input bits [31:1], and the carry-out is input bit 0.
- R7: A register-form amount of 0 outputs the input unchanged, with the carry-out equal to `carry_in`, for all four shift kinds.
- R8: With a register-form amount above 32, a logical left or logical right shift gives a result of 0 and a carry-out of 0. An arithmetic right shift gives every result bit and the carry-out equal to input bit 31.
- R9: A register-form rotate uses the amount modulo 32. For a nonzero amount, the carry-out equals result bit 31. A nonzero multiple of 32 leaves the value unchanged, with carry-out = input bit 31.
- R10: While `rst` is high at a clock edge, `shf_out` and `carry_out` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rm_val | input | 32 | Register value to be shifted |
| op_field | input | 12 | Operand field of the instruction |
| rs_byte | input | 8 | Low byte of the amount register |
| carry_in | input | 1 | Current carry flag |
| shf_out | output | 32 | Registered shifted operand |
| carry_out | output | 1 | Registered shifter carry-out |

## Verification
The assertions assume that the operand field is always well formed. In the register form, bit 7 of the field must be 0, and one assertion watches the input for exactly that. `rs_byte` is taken as meaningful only when bit 4 is set. The stimulus therefore builds every register-form field with bit 7 cleared and varies `rs_byte` freely in both forms. This shows that the byte is ignored in the immediate form and honoured in full, up to 255, in the register form.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shf_kind_e;

  typedef enum logic [1:0] {
    SM_PASS  = 2'b00,
    SM_SHIFT = 2'b01,
    SM_RRX   = 2'b10
  } shf_mode_e;

  localparam int unsigned KIND_LSB  = 5;
  localparam int unsigned FORM_BIT  = 4;
  localparam int unsigned IMM_LSB   = 7;

endpackage

// File: rtl/shf_decode.sv
module shf_decode
  import shf_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OPF_W  = 12,
  parameter int unsigned AMT_W  = 8
) (
  input  logic [OPF_W-1:0] op_field,
  input  logic [AMT_W-1:0] rs_byte,
  output shf_kind_e        kind,
  output shf_mode_e        mode,
  output logic [AMT_W-1:0] amt
);

  localparam int unsigned IMM_W = $clog2(DATA_W);

  logic             reg_form;
  logic [IMM_W-1:0] imm_amt;
  logic [AMT_W-1:0] imm_ext;
  logic             unused_low;

  assign reg_form   = op_field[FORM_BIT];
  assign kind       = shf_kind_e'(op_field[KIND_LSB +: 2]);
  assign imm_amt    = op_field[IMM_LSB +: IMM_W];
  assign imm_ext    = {{(AMT_W-IMM_W){1'b0}}, imm_amt};
  assign unused_low = ^op_field[FORM_BIT-1:0];

  always_comb begin
    mode = SM_SHIFT;
    amt  = imm_ext;
    if (reg_form) begin
      amt = rs_byte;
      if (rs_byte == '0) mode = SM_PASS;
    end else if (imm_amt == '0) begin
      unique case (kind)
        SK_LSL: mode = SM_PASS;
        SK_LSR,
        SK_ASR: amt  = AMT_W'(DATA_W);
        SK_ROR: mode = SM_RRX;
        default: mode = SM_PASS;
      endcase
    end
  end

endmodule

// File: rtl/shf_core.sv
module shf_core
  import shf_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AMT_W  = 8
) (
  input  logic [DATA_W-1:0] x,
  input  logic              cin,
  input  shf_kind_e         kind,
  input  shf_mode_e         mode,
  input  logic [AMT_W-1:0]  amt,
  output logic [DATA_W-1:0] res,
  output logic              cout
);

  localparam int unsigned LOG_W = $clog2(DATA_W);

  logic        [DATA_W:0]   lsl_w;
  logic        [DATA_W:0]   lsr_w;
  logic signed [DATA_W:0]   asr_w;
  logic        [LOG_W-1:0]  rot_amt;
  logic        [DATA_W-1:0] rot_v;

  // Carry rides in the extra bit of each widened shift.
  assign lsl_w   = {1'b0, x} << amt;
  assign lsr_w   = {x, 1'b0} >> amt;
  assign asr_w   = $signed({x, 1'b0}) >>> amt;
  assign rot_amt = amt[LOG_W-1:0];
  assign rot_v   = (x >> rot_amt) | (x << (DATA_W - rot_amt));

  always_comb begin
    res  = x;
    cout = cin;
    unique case (mode)
      SM_PASS: begin
        res  = x;
        cout = cin;
      end
      SM_RRX: begin
        res  = {cin, x[DATA_W-1:1]};
        cout = x[0];
      end
      SM_SHIFT: begin
        unique case (kind)
          SK_LSL: {cout, res} = lsl_w;
          SK_LSR: {res, cout} = lsr_w;
          SK_ASR: {res, cout} = asr_w;
          SK_ROR: begin
            res  = rot_v;
            cout = rot_v[DATA_W-1];
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
  import shf_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OPF_W  = 12,
  parameter int unsigned AMT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] rm_val,
  input  logic [OPF_W-1:0]  op_field,
  input  logic [AMT_W-1:0]  rs_byte,
  input  logic              carry_in,
  output logic [DATA_W-1:0] shf_out,
  output logic              carry_out
);

  shf_kind_e         dec_kind;
  shf_mode_e         dec_mode;
  logic [AMT_W-1:0]  dec_amt;
  logic [DATA_W-1:0] core_res;
  logic              core_cout;

  shf_decode #(.DATA_W(DATA_W), .OPF_W(OPF_W), .AMT_W(AMT_W)) u_dec (
    .op_field (op_field),
    .rs_byte  (rs_byte),
    .kind     (dec_kind),
    .mode     (dec_mode),
    .amt      (dec_amt)
  );

  shf_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
    .x    (rm_val),
    .cin  (carry_in),
    .kind (dec_kind),
    .mode (dec_mode),
    .amt  (dec_amt),
    .res  (core_res),
    .cout (core_cout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      shf_out   <= '0;
      carry_out <= 1'b0;
    end else begin
      shf_out   <= core_res;
      carry_out <= core_cout;
    end
  end

  // ---------------- assertions ----------------
  logic is_reg, is_imm0;
  logic [1:0] kd;
  assign is_reg  = op_field[FORM_BIT];
  assign is_imm0 = !is_reg && (op_field[IMM_LSB +: 5] == 5'd0);
  assign kd      = op_field[KIND_LSB +: 2];

  p_reg_form_bit7_r2: assert property (@(posedge clk) disable iff (rst)
    is_reg |-> !op_field[IMM_LSB]);

  p_lsl_imm0_pass_r4: assert property (@(posedge clk) disable iff (rst)
    (is_imm0 && kd == 2'b00) |=>
      (shf_out == $past(rm_val) && carry_out == $past(carry_in)));

  p_lsr_imm0_full_r5: assert property (@(posedge clk) disable iff (rst)
    (is_imm0 && kd == 2'b01) |=>
      (shf_out == '0 && carry_out == $past(rm_val[DATA_W-1])));

  p_rrx_imm0_r6: assert property (@(posedge clk) disable iff (rst)
    (is_imm0 && kd == 2'b11) |=>
      (shf_out == {$past(carry_in), $past(rm_val[DATA_W-1:1])}
       && carry_out == $past(rm_val[0])));

  p_reg_zero_pass_r7: assert property (@(posedge clk) disable iff (rst)
    (is_reg && rs_byte == '0) |=>
      (shf_out == $past(rm_val) && carry_out == $past(carry_in)));

  p_big_logical_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (is_reg && !kd[1] && rs_byte > AMT_W'(DATA_W)) |=>
      (shf_out == '0 && !carry_out));

  p_ror_carry_top_r9: assert property (@(posedge clk) disable iff (rst)
    (is_reg && kd == 2'b11 && rs_byte != '0) |=>
      (carry_out == shf_out[DATA_W-1]));

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (shf_out == '0 && !carry_out));

endmodule

// File: tb/test_opnd_shifter.sv
module test_opnd_shifter;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] rm_val;
  logic [11:0] op_field;
  logic [7:0]  rs_byte;
  logic        carry_in;
  logic [31:0] shf_out;
  logic        carry_out;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  opnd_shifter i_opnd_shifter (
    .clk(clk), .rst(rst), .rm_val(rm_val), .op_field(op_field),
    .rs_byte(rs_byte), .carry_in(carry_in),
    .shf_out(shf_out), .carry_out(carry_out)
  );

  // Behavioural model: move one bit per step.
  task automatic model(input logic [31:0] x, input logic [11:0] op,
                       input logic [7:0] rsb, input logic cin,
                       output logic [31:0] r, output logic c,
                       output string tag);
    int n;
    logic [1:0] k;
    logic regf;
    k = op[6:5];
    regf = op[4];
    n = regf ? int'(rsb) : int'(op[11:7]);
    r = x;
    c = cin;
    if (regf && n == 0) begin
      tag = "R7";
    end else begin
      case (k)
        2'b00: begin
          tag = (n == 0) ? "R4" : (n > 32 ? "R8" : "R3");
          repeat (n) begin c = r[31]; r = {r[30:0], 1'b0}; end
        end
        2'b01, 2'b10: begin
          if (!regf && n == 0) n = 32;
          tag = (n > 32) ? "R8" : "R5";
          repeat (n) begin
            c = r[0];
            r = {(k == 2'b10) ? r[31] : 1'b0, r[31:1]};
          end
        end
        default: begin
          if (!regf && n == 0) begin
            tag = "R6";
            c = r[0];
            r = {cin, r[31:1]};
          end else begin
            tag = "R9";
            repeat (n) begin c = r[0]; r = {r[0], r[31:1]}; end
          end
        end
      endcase
    end
    if (!regf && n != 0 && tag != "R4" && tag != "R6") tag = {tag, "/R1/R2"};
  endtask

  task automatic apply(input logic [31:0] x, input logic [11:0] op,
                       input logic [7:0] rsb, input logic cin);
    logic [31:0] er;
    logic ec;
    string tag;
    model(x, op, rsb, cin, er, ec, tag);
    rm_val = x; op_field = op; rs_byte = rsb; carry_in = cin;
    @(posedge clk);
    @(negedge clk);
    n_vec++;
    if (shf_out !== er || carry_out !== ec) begin
      n_bad++;
      $display("FAIL %s op=%h amt_byte=%0d x=%h cin=%b: actual %h/%b expected %h/%b",
               tag, op, rsb, x, cin, shf_out, carry_out, er, ec);
    end
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected below 100000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'h8000_0001;
    pats[1] = 32'h7F3C_A5E6;
    pats[2] = 32'hFFFF_FFFE;
    pats[3] = 32'hC35A_0F96;

    // R10: reset clears the registered outputs even with live inputs
    rst = 1'b1;
    rm_val = 32'hDEAD_BEEF; op_field = 12'h000; rs_byte = 8'h00; carry_in = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    n_vec++;
    if (shf_out !== 32'h0 || carry_out !== 1'b0) begin
      n_bad++;
      $display("FAIL R10 reset: actual %h/%b expected 00000000/0", shf_out, carry_out);
    end
    rst = 1'b0;

    // R1 R2 R3 R4 R5 R6: immediate amounts 0..31, all kinds; rs_byte must be ignored
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 4; k++)
        for (int a = 0; a < 32; a++)
          apply(pats[p], {a[4:0], k[1:0], 1'b0, 4'h3},
                8'(a * 7 + p), 1'((a + p) & 1));

    // R2 R7 R8 R9: register amounts 0..255, bit 7 of the field cleared
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 4; k++)
        for (int a = 0; a < 256; a++)
          apply(pats[p] ^ 32'(a * 32'h0101_0101), {4'h5, 1'b0, k[1:0], 1'b1, 4'h2},
                8'(a), 1'((a >> 1) & 1));

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule